// File: doc/BRIEF.md
# Boot Stage Watchdog Timer

This block guards the power-on self-test stage of a host's boot. Firmware arms it with a strobe and then disarms it once the self-test has finished. Firmware disarms it before it scans add-in ROMs, before it enters setup, or before it prompts for a boot password. While the timer runs, its countdown advances only on a slow enable tick, normally once per second. The default count of 600 ticks gives ten minutes. A single output flag tells the earlier boot stage that its own timer may now be stopped. The flag is high only while this timer is armed, so the two timers always overlap and coverage never lapses.

Firmware writes a byte-wide progress code on a strobe. If the count runs out, the most recent code is frozen into an event record, and that record is offered once on a valid/ready output. The event is kept until the consumer accepts it. It is never withdrawn or changed while it waits, and the consumer may hold ready low for as long as it needs. Two configuration pins are sampled at the moment of expiry. The first chooses between "reset" and "none" as the action. The second, which is meant to be held low unless the system explicitly enables it, adds a request to disable the boot processor. The requests stay asserted until the timer is disarmed or armed again.

Top module: `bootstage_watchdog`

## Requirements
- R1: After reset, evt_valid, rst_req, cpu_dis_req and prev_disarm_ok are all low and the timer is idle.
- R2: An arm strobe without disarm loads the full count of TIMEOUT_TICKS. prev_disarm_ok is high from the next cycle. An arm while the timer is already running restarts the full count.
- R3: The count advances only in cycles where tick is high. Expiry happens on the TIMEOUT_TICKS-th tick after the last arm. Its results appear on the outputs in the cycle after that tick, and prev_disarm_ok falls at the same moment.
- R4: A disarm strobe returns the timer to idle, drops prev_disarm_ok and clears rst_req and cpu_dis_req. A disarm received before the final tick prevents the event. When disarm and arm arrive in the same cycle, disarm wins.
- R5: A progress-code strobe stores code_in. The event carries the most recent code, and a write in the expiry cycle itself is included.
- R6: cfg_act_reset is sampled at expiry. When it is 1, rst_req rises and stays high until the next arm or disarm. When it is 0, the event is still produced but rst_req stays low.
- R7: cpu_dis_req is raised only when both cfg_act_reset and cfg_cpu_off are 1 at expiry. It clears together with rst_req.
- R8: Expiry is one-shot. After it, further ticks produce no event and change no output until the next arm.
- R9: Once evt_valid is high, it and evt_code hold steady until a cycle with evt_ready high. The transfer takes place in that cycle, and evt_valid is low afterwards unless a new event is loaded.
- R10: If an expiry occurs while an earlier event is still waiting and evt_ready is low, the waiting event is kept and the new one is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable, one pulse per second |
| arm | input | 1 | Arm or restart strobe |
| disarm | input | 1 | Disarm strobe |
| cfg_act_reset | input | 1 | Expiry action: 1 = reset, 0 = none |
| cfg_cpu_off | input | 1 | Also request boot processor disable on expiry |
| code_wr | input | 1 | Progress code write strobe |
| code_in | input | 8 | Progress code value |
| evt_valid | output | 1 | Expiry event offered |
| evt_ready | input | 1 | Consumer accepts the event |
| evt_code | output | 8 | Progress code frozen at expiry |
| rst_req | output | 1 | System reset request |
| cpu_dis_req | output | 1 | Boot processor disable request |
| prev_disarm_ok | output | 1 | Earlier-stage timer may be stopped |

## Verification
The bench writes a code in the same cycle as the final tick. A design that samples the stored register instead of the bypass would report the stale code. It restarts the count halfway through, which catches a design that ignores a re-arm and expires early. It also keeps ticking after expiry, where a timer that is not one-shot would emit a second, unexpected event. Finally, it holds ready low across a second expiry. A slot that is overwritten, or an event that is withdrawn, shows up there as a changed code or a wrong pop order in the scoreboard.

// File: rtl/bsw_pkg.sv
package bsw_pkg;

  typedef enum logic [1:0] {
    BSW_IDLE    = 2'd0,
    BSW_ARMED   = 2'd1,
    BSW_EXPIRED = 2'd2
  } bsw_state_e;

  typedef struct packed {
    logic sys_reset;
    logic cpu_off;
  } bsw_req_t;

endpackage

// File: rtl/bsw_countdown.sv
module bsw_countdown
  import bsw_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       arm,
  input  logic       disarm,
  output bsw_state_e state,
  output logic       expire
);
  localparam int CW = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [CW-1:0] LOAD = CW'(TIMEOUT_TICKS);
  localparam logic [CW-1:0] LAST = CW'(1);

  bsw_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          start;

  assign start  = arm && !disarm;
  assign expire = (state_q == BSW_ARMED) && tick && (cnt_q == LAST) && !arm && !disarm;
  assign state  = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BSW_IDLE;
      cnt_q   <= '0;
    end else if (disarm) begin
      state_q <= BSW_IDLE;
      cnt_q   <= '0;
    end else if (start) begin
      state_q <= BSW_ARMED;
      cnt_q   <= LOAD;
    end else if (expire) begin
      state_q <= BSW_EXPIRED;
      cnt_q   <= '0;
    end else if ((state_q == BSW_ARMED) && tick) begin
      cnt_q   <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/bsw_code_latch.sv
module bsw_code_latch #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_wr,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] snapshot
);
  logic [CODE_W-1:0] code_q;

  assign snapshot = code_wr ? code_in : code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (code_wr) code_q <= code_in;
  end
endmodule

// File: rtl/bsw_request.sv
module bsw_request
  import bsw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clear,
  input  logic     expire,
  input  logic     act_reset,
  input  logic     cpu_off,
  output bsw_req_t req
);
  bsw_req_t req_q;

  assign req = req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
    end else if (clear) begin
      req_q <= '0;
    end else if (expire) begin
      req_q.sys_reset <= act_reset;
      req_q.cpu_off   <= act_reset && cpu_off;
    end
  end
endmodule

// File: rtl/bsw_event_slot.sv
module bsw_event_slot #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] load_code,
  output logic              valid,
  input  logic              ready,
  output logic [CODE_W-1:0] code
);
  logic              valid_q;
  logic [CODE_W-1:0] code_q;
  logic              room;

  assign room  = !valid_q || ready;
  assign valid = valid_q;
  assign code  = code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      code_q  <= '0;
    end else if (load && room) begin
      valid_q <= 1'b1;
      code_q  <= load_code;
    end else if (valid_q && ready) begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/bootstage_watchdog.sv
module bootstage_watchdog
  import bsw_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 600,
  parameter int CODE_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              arm,
  input  logic              disarm,
  input  logic              cfg_act_reset,
  input  logic              cfg_cpu_off,
  input  logic              code_wr,
  input  logic [CODE_W-1:0] code_in,
  output logic              evt_valid,
  input  logic              evt_ready,
  output logic [CODE_W-1:0] evt_code,
  output logic              rst_req,
  output logic              cpu_dis_req,
  output logic              prev_disarm_ok
);
  bsw_state_e        state;
  logic              expire;
  logic [CODE_W-1:0] snap;
  bsw_req_t          req;

  bsw_countdown #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .arm(arm), .disarm(disarm),
    .state(state), .expire(expire)
  );

  bsw_code_latch #(.CODE_W(CODE_W)) u_code (
    .clk(clk), .rst_n(rst_n), .code_wr(code_wr), .code_in(code_in),
    .snapshot(snap)
  );

  bsw_request u_req (
    .clk(clk), .rst_n(rst_n), .clear(arm || disarm), .expire(expire),
    .act_reset(cfg_act_reset), .cpu_off(cfg_cpu_off), .req(req)
  );

  bsw_event_slot #(.CODE_W(CODE_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .load(expire), .load_code(snap),
    .valid(evt_valid), .ready(evt_ready), .code(evt_code)
  );

  assign rst_req        = req.sys_reset;
  assign cpu_dis_req    = req.cpu_off;
  assign prev_disarm_ok = (state == BSW_ARMED);
endmodule

// File: rtl/bsw_checker.sv
module bsw_checker #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              arm,
  input logic              disarm,
  input logic              evt_valid,
  input logic              evt_ready,
  input logic [CODE_W-1:0] evt_code,
  input logic              rst_req,
  input logic              cpu_dis_req,
  input logic              prev_disarm_ok
);
  a_r2_arm_covers: assert property (@(posedge clk) disable iff (!rst_n)
    arm && !disarm |=> prev_disarm_ok);

  a_r3_no_expiry_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    prev_disarm_ok && !tick && !disarm |=> prev_disarm_ok);

  a_r4_disarm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    disarm |=> !prev_disarm_ok && !rst_req && !cpu_dis_req);

  a_r7_cpu_needs_reset: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_dis_req |-> rst_req);

  a_r8_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    !prev_disarm_ok && !arm |=> !prev_disarm_ok);

  a_r8_event_from_armed: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid && !prev_disarm_ok |=> !evt_valid);

  a_r9_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !evt_ready |=> evt_valid && $stable(evt_code));
endmodule

bind bootstage_watchdog bsw_checker #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .arm(arm), .disarm(disarm),
  .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_code(evt_code),
  .rst_req(rst_req), .cpu_dis_req(cpu_dis_req), .prev_disarm_ok(prev_disarm_ok)
);

// File: tb/bootstage_watchdog_bench.sv
module bootstage_watchdog_bench;
  localparam int TT = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 0, arm = 0, disarm = 0, cfg_act_reset = 0, cfg_cpu_off = 0;
  logic       code_wr = 0, evt_ready = 1;
  logic [7:0] code_in = '0;
  logic       evt_valid, rst_req, cpu_dis_req, prev_disarm_ok;
  logic [7:0] evt_code;

  int n_checks = 0, n_fail = 0, cycles = 0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  bootstage_watchdog #(.TIMEOUT_TICKS(TT), .CODE_W(8)) u_bootstage_watchdog (
    .clk(clk), .rst_n(rst_n), .tick(tick), .arm(arm), .disarm(disarm),
    .cfg_act_reset(cfg_act_reset), .cfg_cpu_off(cfg_cpu_off),
    .code_wr(code_wr), .code_in(code_in), .evt_valid(evt_valid),
    .evt_ready(evt_ready), .evt_code(evt_code), .rst_req(rst_req),
    .cpu_dis_req(cpu_dis_req), .prev_disarm_ok(prev_disarm_ok)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // monitor: pops the scoreboard on each accepted event
  always @(posedge clk) begin
    if (rst_n && evt_valid && evt_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected event", evt_code, 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(evt_code == e, "R5 event code", evt_code, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      check(1'b0, "watchdog", cycles, 20000);
      finish_run();
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_arm();
    @(negedge clk) arm = 1;
    @(negedge clk) arm = 0;
  endtask

  task automatic pulse_disarm();
    @(negedge clk) disarm = 1;
    @(negedge clk) disarm = 0;
  endtask

  task automatic write_code(input logic [7:0] c);
    @(negedge clk) begin code_wr = 1; code_in = c; end
    @(negedge clk) code_wr = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
      idle(1);
    end
  endtask

  initial begin
    idle(3);
    check(!evt_valid && !rst_req && !cpu_dis_req && !prev_disarm_ok, "R1 reset outputs",
          {evt_valid, rst_req, cpu_dis_req, prev_disarm_ok}, 0);
    @(negedge clk) rst_n = 1;
    idle(2);

    // expiry with reset action, code written on the final tick
    cfg_act_reset = 1;
    write_code(8'h11);
    pulse_arm();
    check(prev_disarm_ok, "R2 armed flag", prev_disarm_ok, 1);
    ticks(TT - 1);
    check(prev_disarm_ok && !evt_valid && !rst_req, "R3 not yet expired",
          {prev_disarm_ok, evt_valid, rst_req}, 3'b100);
    exp_q.push_back(8'h5A);
    @(negedge clk) begin tick = 1; code_wr = 1; code_in = 8'h5A; end
    @(negedge clk) begin tick = 0; code_wr = 0; end
    check(evt_valid && evt_code == 8'h5A, "R5 bypass code", evt_code, 8'h5A);
    check(rst_req && !cpu_dis_req, "R6/R7 reset only", {rst_req, cpu_dis_req}, 2'b10);
    check(!prev_disarm_ok, "R3 flag drops on expiry", prev_disarm_ok, 0);
    idle(2);
    check(!evt_valid, "R9 valid drops after transfer", evt_valid, 0);

    // one-shot
    ticks(TT + 3);
    check(rst_req && !prev_disarm_ok && !evt_valid, "R8 one shot",
          {rst_req, prev_disarm_ok, evt_valid}, 3'b100);
    pulse_disarm();
    check(!rst_req && !prev_disarm_ok, "R4 disarm clears", {rst_req, prev_disarm_ok}, 0);

    // restart mid-count, processor disable
    cfg_cpu_off = 1;
    write_code(8'h33);
    pulse_arm();
    ticks(4);
    pulse_arm();
    ticks(TT - 1);
    check(prev_disarm_ok && !evt_valid, "R2 rearm restarts count", prev_disarm_ok, 1);
    exp_q.push_back(8'h33);
    ticks(1);
    check(rst_req && cpu_dis_req, "R7 processor disable", {rst_req, cpu_dis_req}, 2'b11);
    pulse_arm();
    check(!rst_req && !cpu_dis_req, "R6 arm clears requests", {rst_req, cpu_dis_req}, 0);

    // action none
    @(negedge clk) cfg_act_reset = 0;
    write_code(8'h44);
    exp_q.push_back(8'h44);
    ticks(TT);
    check(!rst_req && !cpu_dis_req && !prev_disarm_ok, "R6 action none",
          {rst_req, cpu_dis_req, prev_disarm_ok}, 0);
    idle(2);

    // disarm before the last tick, then simultaneous strobes
    cfg_act_reset = 1;
    pulse_arm();
    ticks(TT - 1);
    pulse_disarm();
    ticks(TT + 2);
    check(!evt_valid && !rst_req && !prev_disarm_ok, "R4 disarm prevents event",
          {evt_valid, rst_req, prev_disarm_ok}, 0);
    @(negedge clk) begin arm = 1; disarm = 1; end
    @(negedge clk) begin arm = 0; disarm = 0; end
    check(!prev_disarm_ok, "R4 disarm wins", prev_disarm_ok, 0);

    // back-pressure and overflow
    @(negedge clk) evt_ready = 0;
    write_code(8'h77);
    pulse_arm();
    exp_q.push_back(8'h77);
    ticks(TT);
    idle(3);
    check(evt_valid && evt_code == 8'h77, "R9 held under back-pressure", evt_code, 8'h77);
    write_code(8'h88);
    pulse_arm();
    ticks(TT);
    check(evt_valid && evt_code == 8'h77, "R10 waiting event kept", evt_code, 8'h77);
    @(negedge clk) evt_ready = 1;
    @(negedge clk);
    check(!evt_valid, "R10 dropped event not offered", evt_valid, 0);
    idle(3);
    check(exp_q.size() == 0, "R9 all events delivered", exp_q.size(), 0);
    finish_run();
  end
endmodule